// File: doc/BRIEF.md
# Two-Port GPIO Register Bank with Change Interrupt

This block is the register core of a sixteen-pin general-purpose I/O expander. The pins are grouped into two byte-wide ports. Each port has four registers: the sampled input levels, the stored output levels, a polarity mask and a direction mask. An upstream bus agent, such as a serial slave controller, reaches them through a simple register port. That port has a three-bit address, single-cycle read and write strobes and byte-wide data. The block drives a per-pin output value and output enable from the stored registers.

Pin inputs pass through a synchronizer before use. When software reads a port's input register, the block keeps a copy of that port's synchronized pin levels. This copy is the baseline for change detection. An input-direction pin whose level differs from its baseline raises the interrupt, which is presented as the enable of an open-drain, active-low line. The interrupt clears when the pin returns to its baseline or when that port's input register is read. Output-direction pins never take part.

Top module: `gpio_xp_bank`

## Requirements
- R1: After reset the output registers read 0xFF, the polarity registers 0x00 and the direction registers 0xFF. pin_oe is all zero and int_oe is 0.
- R2: A direction bit of 1 makes its pin an input, with pin_oe low. A direction bit of 0 sets pin_oe high, and pin_out then carries the matching output-register bit.
- R3: Reading an input register returns the synchronized pin levels XOR the polarity register. This holds whatever the direction of each pin. A polarity bit of 1 inverts and 0 passes.
- R4: Writes to the input-register addresses (0 and 1) change no register and no pin output.
- R5: Reading an output register returns the stored value, not the level on the pin.
- R6: int_oe goes to 1 when an input-direction pin differs from the baseline captured at its port's last input read.
- R7: int_oe returns to 0 once every such pin is back at its baseline.
- R8: A read of one port's input register re-captures only that port's baseline. The interrupt contribution of the other port remains.
- R9: Pins whose direction bit is 0 never cause int_oe.
- R10: Changing a pin from output to input raises int_oe if its level differs from the stored baseline.
- R11: The address is {kind[1:0], port}. Kind 0 is input, 1 is output, 2 is polarity and 3 is direction. The output, polarity and direction registers read back the last value written.
- R12: reg_rdata is registered. It takes the addressed value at the clock edge that samples reg_rd, and it holds that value while reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address {kind, port} |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels, port 1 in the upper byte |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Per-pin output enable |
| int_oe | output | 1 | Open-drain interrupt enable; 1 pulls the line low |

## Verification
The bench builds the block with its default parameters: two ports of eight pins and a two-stage synchronizer. At this size every one of the eight addresses maps to a real register, so the bench can probe both port-selection paths directly. That includes clearing one port's interrupt while the other port's contribution stays. Pin changes are given enough cycles to pass through the synchronizer and the interrupt register before they are checked. Direction changes with a stale baseline exercise the output-to-input interrupt case.

// File: rtl/gpio_xp_pkg.sv
package gpio_xp_pkg;
   typedef enum logic [1:0] {
      KIND_IN  = 2'd0,
      KIND_OUT = 2'd1,
      KIND_POL = 2'd2,
      KIND_DIR = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/gpio_xp_sync.sv
module gpio_xp_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   initial begin
      AST_SYNC_DEPTH: assert (STAGES >= 2 && WIDTH >= 1)
         else $error("synchronizer needs two stages and a nonzero width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '1;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '1;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_xp_port.sv
module gpio_xp_port
   import gpio_xp_pkg::*;
#(
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  reg_kind_e         kind,
   input  logic              wr,
   input  logic              rd,
   input  logic [PORT_W-1:0] wdata,
   input  logic [PORT_W-1:0] pins_s,
   output logic [PORT_W-1:0] out_q,
   output logic [PORT_W-1:0] dir_q,
   output logic [PORT_W-1:0] rd_val,
   output logic [PORT_W-1:0] mismatch
);
   logic [PORT_W-1:0] pol_q;
   logic [PORT_W-1:0] snap_q;
   logic              wr_out, wr_pol, wr_dir, rd_in;

   assign wr_out = sel && wr && (kind == KIND_OUT);
   assign wr_pol = sel && wr && (kind == KIND_POL);
   assign wr_dir = sel && wr && (kind == KIND_DIR);
   assign rd_in  = sel && rd && (kind == KIND_IN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '1;
         pol_q  <= '0;
         dir_q  <= '1;
         snap_q <= '1;
      end else begin
         if (wr_out) out_q  <= wdata;
         if (wr_pol) pol_q  <= wdata;
         if (wr_dir) dir_q  <= wdata;
         if (rd_in)  snap_q <= pins_s;
      end
   end

   always_comb begin
      case (kind)
         KIND_IN:  rd_val = pins_s ^ pol_q;
         KIND_OUT: rd_val = out_q;
         KIND_POL: rd_val = pol_q;
         default:  rd_val = dir_q;
      endcase
   end

   assign mismatch = (pins_s ^ snap_q) & dir_q;

   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> dir_q == $past(wdata)); // R11
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_out |=> $stable(out_q)); // R5
   AST_SNAP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_in |=> snap_q == $past(pins_s)); // R8
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_in |=> $stable(snap_q)); // R8
endmodule

// File: rtl/gpio_xp_irq.sv
module gpio_xp_irq #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] mismatch,
   output logic         int_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) int_oe <= 1'b0;
      else        int_oe <= |mismatch;
   end
endmodule

// File: rtl/gpio_xp_bank.sv
module gpio_xp_bank
   import gpio_xp_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int NUM_PORTS   = 2,
   parameter int SYNC_STAGES = 2,
   localparam int PSEL_W     = $clog2(NUM_PORTS),
   localparam int ADDR_W     = PSEL_W + 2,
   localparam int PIN_W      = PORT_W * NUM_PORTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [PORT_W-1:0] reg_wdata,
   output logic [PORT_W-1:0] reg_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe,
   output logic              int_oe
);
   initial begin
      AST_PARAM_SHAPE: assert (NUM_PORTS >= 2 && (1 << PSEL_W) == NUM_PORTS && PORT_W >= 1)
         else $error("port count must be a power of two of at least two");
   end

   reg_kind_e                             kind;
   logic [PSEL_W-1:0]                     port_idx;
   logic [PIN_W-1:0]                      pins_s;
   logic [NUM_PORTS-1:0][PORT_W-1:0]      rd_vals;
   logic [NUM_PORTS-1:0][PORT_W-1:0]      out_all;
   logic [NUM_PORTS-1:0][PORT_W-1:0]      dir_all;
   logic [NUM_PORTS-1:0][PORT_W-1:0]      mis_all;

   assign kind     = reg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
   assign port_idx = reg_addr[PSEL_W-1:0];

   gpio_xp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pins_s)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic sel;
      assign sel = (port_idx == PSEL_W'(p));
      gpio_xp_port #(.PORT_W(PORT_W)) u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (sel),
         .kind     (kind),
         .wr       (reg_wr),
         .rd       (reg_rd),
         .wdata    (reg_wdata),
         .pins_s   (pins_s[p*PORT_W +: PORT_W]),
         .out_q    (out_all[p]),
         .dir_q    (dir_all[p]),
         .rd_val   (rd_vals[p]),
         .mismatch (mis_all[p])
      );
   end

   assign pin_out = out_all;
   assign pin_oe  = ~dir_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_vals[port_idx];
   end

   gpio_xp_irq #(.N(PIN_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mismatch (mis_all),
      .int_oe   (int_oe)
   );

   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|mis_all) |=> int_oe); // R6
   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !(|mis_all) |=> !int_oe); // R7
   AST_INPUT_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && kind == KIND_IN) |=> ($stable(pin_out) && $stable(pin_oe))); // R4
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata)); // R12
endmodule

// File: tb/tb_gpio_xp_bank.sv
`timescale 1ns/1ps
module tb_gpio_xp_bank;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  reg_addr;
   logic        reg_wr, reg_rd;
   logic [7:0]  reg_wdata;
   logic [7:0]  reg_rdata;
   logic [15:0] pin_in, pin_out, pin_oe;
   logic        int_oe;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   gpio_xp_bank dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .int_oe(int_oe)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic do_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic rebase();
      logic [7:0] d;
      settle();
      do_read(3'd0, d);
      do_read(3'd1, d);
      settle();
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 pin_oe", pin_oe, 16'h0000);
      chk("R1 int_oe", {15'd0, int_oe}, 16'd0);
      do_read(3'd2, d); chk("R1 out0", {8'd0, d}, 16'h00FF);
      do_read(3'd3, d); chk("R1 out1", {8'd0, d}, 16'h00FF);
      do_read(3'd4, d); chk("R1 pol0", {8'd0, d}, 16'h0000);
      do_read(3'd5, d); chk("R1 pol1", {8'd0, d}, 16'h0000);
      do_read(3'd6, d); chk("R1 dir0", {8'd0, d}, 16'h00FF);
      do_read(3'd7, d); chk("R1 dir1", {8'd0, d}, 16'h00FF);
   endtask

   task automatic t_direction();
      do_write(3'd6, 8'hF0);
      do_write(3'd2, 8'hA5);
      @(negedge clk);
      chk("R2 oe", pin_oe, 16'h000F);
      chk("R2 driven value", pin_out & pin_oe, 16'h0005);
   endtask

   task automatic t_out_readback();
      logic [7:0] d;
      pin_in = 16'h0000;
      settle();
      do_read(3'd2, d);
      chk("R5 out0 stored not pin", {8'd0, d}, 16'h00A5);
      pin_in = 16'hFFFF;
      rebase();
   endtask

   task automatic t_input_read();
      logic [7:0] d;
      do_write(3'd5, 8'hFF);
      pin_in = 16'h3C5A;
      settle();
      do_read(3'd0, d);
      chk("R3 in0 incl. output pins", {8'd0, d}, 16'h005A);
      do_read(3'd1, d);
      chk("R3 in1 inverted", {8'd0, d}, 16'h00C3);
      pin_in = 16'h3C00;
      settle();
      chk("R12 rdata holds", {8'd0, reg_rdata}, 16'h00C3);
      do_write(3'd5, 8'h00);
      pin_in = 16'hFFFF;
      rebase();
   endtask

   task automatic t_input_write();
      logic [7:0] d;
      logic [15:0] oe0, po0;
      oe0 = pin_oe; po0 = pin_out;
      do_write(3'd0, 8'h00);
      do_write(3'd1, 8'h12);
      @(negedge clk);
      chk("R4 oe unchanged", pin_oe, oe0);
      chk("R4 out unchanged", pin_out, po0);
      do_read(3'd0, d); chk("R4 in0 still pins", {8'd0, d}, 16'h00FF);
      do_read(3'd1, d); chk("R4 in1 still pins", {8'd0, d}, 16'h00FF);
      do_read(3'd4, d); chk("R4 pol0", {8'd0, d}, 16'h0000);
      do_read(3'd7, d); chk("R4 dir1", {8'd0, d}, 16'h00FF);
   endtask

   task automatic t_irq_basic();
      do_write(3'd6, 8'hFF);
      do_write(3'd7, 8'hFF);
      pin_in = 16'hFFFF;
      rebase();
      chk("R7 idle after baseline", {15'd0, int_oe}, 16'd0);
      pin_in[3] = 1'b0;
      settle();
      chk("R6 raise on change", {15'd0, int_oe}, 16'd1);
      pin_in[3] = 1'b1;
      settle();
      chk("R7 drop on return", {15'd0, int_oe}, 16'd0);
   endtask

   task automatic t_irq_per_port();
      logic [7:0] d;
      pin_in = 16'hFDFB;
      settle();
      chk("R6 two ports changed", {15'd0, int_oe}, 16'd1);
      do_read(3'd1, d);
      chk("R8 in1 value", {8'd0, d}, 16'h00FD);
      settle();
      chk("R8 port0 still pending", {15'd0, int_oe}, 16'd1);
      do_read(3'd0, d);
      chk("R8 in0 value", {8'd0, d}, 16'h00FB);
      settle();
      chk("R8 cleared by port0 read", {15'd0, int_oe}, 16'd0);
      pin_in = 16'hFFFF;
      rebase();
   endtask

   task automatic t_output_pins();
      do_write(3'd6, 8'h00);
      pin_in = 16'hFF00;
      settle();
      chk("R9 output pins silent", {15'd0, int_oe}, 16'd0);
      do_write(3'd6, 8'hFF);
      settle();
      chk("R10 out-to-in raises", {15'd0, int_oe}, 16'd1);
      pin_in = 16'hFFFF;
      rebase();
   endtask

   task automatic t_reg_rw();
      logic [7:0] d;
      do_write(3'd5, 8'h96);
      do_write(3'd7, 8'h3C);
      do_write(3'd3, 8'h81);
      do_read(3'd5, d); chk("R11 pol1", {8'd0, d}, 16'h0096);
      do_read(3'd7, d); chk("R11 dir1", {8'd0, d}, 16'h003C);
      do_read(3'd3, d); chk("R11 out1", {8'd0, d}, 16'h0081);
      chk("R2 port1 oe", {8'd0, pin_oe[15:8]}, 16'h00C3);
      chk("R2 port1 driven", {8'd0, pin_out[15:8] & pin_oe[15:8]}, 16'h0081);
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
      reg_wdata = '0; pin_in = 16'hFFFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direction();
      t_out_readback();
      t_input_read();
      t_input_write();
      t_irq_basic();
      t_irq_per_port();
      t_output_pins();
      t_reg_rw();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule